// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block translates the effective address of each load or store into a physical address. It uses a single-way table of 32 entries, indexed by set, and a fixed page size of 8 KB. Each entry has two halves. The match half holds a virtual page number and a valid flag. The translate half holds a physical page number, a cache-inhibit flag and four access-enable flags. There is one enable flag for each pairing of privilege (supervisor or user) with access kind (read or write). The table is loaded only by software through a small special-register port. There is no hardware table walker. When an access misses, software refills the entry. When an access faults, software repairs the permissions.

A request is captured on a clock edge together with the translation-enable level. In the following cycle the block gives exactly one outcome: a translated access, a miss, or a permission fault. A translated access carries the physical address, the cache-inhibit flag and a write strobe. A miss or a fault carries no address and no strobe. On either of these the effective address is latched for the handler. With translation switched off, every request passes through unchanged.

Top module: `dtlb_xlate`

## Requirements
- R1: On a hit with translation enabled, `acc_pa` is the entry's physical page number in bits [31:13], followed by request address bits [12:0] unchanged.
- R2: The entry used for a lookup is the set selected by request address bits [17:13]. An entry written to one set has no effect on addresses that select another set.
- R3: A hit requires the valid flag to be set and the stored page number to equal request address bits [31:13] in every bit. Any accesses to other offsets of a page already loaded hit again and raise no miss.
- R4: `acc_miss` is raised when the selected entry is invalid or its page number differs. A miss takes priority: the same access raises no fault, whatever the permission flags hold.
- R5: On a hit, `acc_fault` is raised when the enable flag for the request's mode and kind is clear. The translate word flags are: bit 1 supervisor read, bit 2 supervisor write, bit 3 user read, bit 4 user write.
- R6: Writing a match word with bit 0 clear invalidates the entry, whether the word is all zero or keeps its page number. The next access to that page misses.
- R7: With `xl_en` low when the request is captured, the block does not translate. `acc_pa` equals the request address, `acc_ok` is high, and neither a miss nor a fault is raised.
- R8: `fault_ea` resets to zero. It loads the request address on the clock edge that ends a miss or fault cycle and holds its value otherwise.
- R9: At most one of `acc_ok`, `acc_miss` and `acc_fault` is high, and only in the cycle after a captured request. During a miss or fault, `acc_pa` is zero and `acc_wr_stb` is low. `acc_wr_stb` is high only for a write that is granted.
- R10: The special-register port selects the match word with `spr_sel`=0 and the translate word with `spr_sel`=1, at set `spr_set`. A write takes effect at the clock edge. A read is combinational. The match word reads back bits [31:13] and bit 0 with the other bits zero. The translate word reads back bits [31:13] and [4:0] with the other bits zero.
- R11: Reset clears every entry to zero (all invalid) and clears the captured request, so all outcome outputs are low.
- R12: On a hit, `acc_ci` reflects translate-word bit 0 (cache inhibit). It is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_en | input | 1 | Translation enable, captured with each request |
| req_vld | input | 1 | Load/store request strobe |
| req_we | input | 1 | Request is a store (1) or a load (0) |
| req_sup | input | 1 | Request is made in supervisor mode |
| req_ea | input | 32 | Effective address of the request |
| acc_ok | output | 1 | Access translated and granted |
| acc_miss | output | 1 | No valid matching entry |
| acc_fault | output | 1 | Matching entry denies this access |
| acc_pa | output | 32 | Physical address, valid with `acc_ok` |
| acc_ci | output | 1 | Cache-inhibit flag of the granted access |
| acc_wr_stb | output | 1 | Write strobe for a granted store |
| fault_ea | output | 32 | Latched address of the last miss or fault |
| spr_we | input | 1 | Special-register write strobe |
| spr_sel | input | 1 | 0 selects the match word, 1 the translate word |
| spr_set | input | 5 | Set index of the register access |
| spr_wdata | input | 32 | Special-register write data |
| spr_rdata | output | 32 | Special-register read data |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 13 offset bits and 5 set-index bits. At these values every one of the 32 sets can be reached, and a single bit walked through positions 13 to 31 covers each compared page-number bit and each set-index bit. A behavioural model with its own word tables predicts every output, the read port and the latched fault address on each clock. Directed phases cover the four permission flags one at a time, invalidation that keeps the page number, miss-over-fault priority and bypass. These are followed by a random phase confined to four sets and two upper page numbers, so that hits, misses, faults and rewrites collide often.

// File: rtl/dtlb_pkg.sv
// Shared types for the data translation buffer.
// Assumes: the permission flags sit in the low five bits of the translate word.
package dtlb_pkg;

    // Permission/attribute flags of a translate word, bit 4 down to bit 0.
    typedef struct packed {
        logic usr_wr;    // bit 4: user store allowed
        logic usr_rd;    // bit 3: user load allowed
        logic sup_wr;    // bit 2: supervisor store allowed
        logic sup_rd;    // bit 1: supervisor load allowed
        logic no_cache;  // bit 0: cache inhibit
    } dtlb_perm_t;

    localparam int PERM_W = 5;

    // Register-port selector.
    typedef enum logic {
        SEL_MATCH = 1'b0,
        SEL_XLATE = 1'b1
    } dtlb_sel_e;

endpackage

// File: rtl/dtlb_store.sv
// Entry storage with the special-register port.
// Holds one match half (page number, valid) and one translate half
// (page number, flags) per set. Writes land on the clock edge. Register
// reads and the lookup read port are combinational.
// Assumes: PAGE_BITS > PERM_W so the reserved fields are non-empty.
module dtlb_store
    import dtlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int SET_BITS  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spr_we,
    input  logic                spr_sel,
    input  logic [SET_BITS-1:0] spr_set,
    input  logic [ADDR_W-1:0]   spr_wdata,
    output logic [ADDR_W-1:0]   spr_rdata,
    input  logic [SET_BITS-1:0] lk_set,
    output logic                lk_valid,
    output logic [ADDR_W-PAGE_BITS-1:0] lk_vpn,
    output logic [ADDR_W-PAGE_BITS-1:0] lk_ppn,
    output dtlb_perm_t          lk_perm
);
    localparam int NUM_SETS = 1 << SET_BITS;
    localparam int PN_W     = ADDR_W - PAGE_BITS;
    localparam int PAD_MR   = PAGE_BITS - 1;
    localparam int PAD_TR   = PAGE_BITS - PERM_W;

    logic              rd_v    [NUM_SETS];
    logic [PN_W-1:0]   rd_vpn  [NUM_SETS];
    logic [PN_W-1:0]   rd_ppn  [NUM_SETS];
    dtlb_perm_t        rd_perm [NUM_SETS];

    // Reserved write-data bits are ignored on purpose.
    logic unused_wbits;
    assign unused_wbits = ^spr_wdata[PAGE_BITS-1:1];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic            v_q;
        logic [PN_W-1:0] vpn_q;
        logic [PN_W-1:0] ppn_q;
        dtlb_perm_t      perm_q;
        logic            hit_sel;

        assign hit_sel = spr_we && (spr_set == SET_BITS'(s));

        // Update this set's match and translate halves from the register port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                vpn_q  <= '0;
                ppn_q  <= '0;
                perm_q <= '0;
            end else if (hit_sel && spr_sel == SEL_MATCH) begin
                v_q   <= spr_wdata[0];
                vpn_q <= spr_wdata[ADDR_W-1:PAGE_BITS];
            end else if (hit_sel && spr_sel == SEL_XLATE) begin
                ppn_q  <= spr_wdata[ADDR_W-1:PAGE_BITS];
                perm_q <= dtlb_perm_t'(spr_wdata[PERM_W-1:0]);
            end
        end

        assign rd_v[s]    = v_q;
        assign rd_vpn[s]  = vpn_q;
        assign rd_ppn[s]  = ppn_q;
        assign rd_perm[s] = perm_q;
    end

    // Register read: rebuild the selected word with reserved bits at zero.
    always_comb begin
        if (spr_sel == SEL_XLATE)
            spr_rdata = {rd_ppn[spr_set], {PAD_TR{1'b0}}, rd_perm[spr_set]};
        else
            spr_rdata = {rd_vpn[spr_set], {PAD_MR{1'b0}}, rd_v[spr_set]};
    end

    // Lookup read of the set addressed by the captured request.
    always_comb begin
        lk_valid = rd_v[lk_set];
        lk_vpn   = rd_vpn[lk_set];
        lk_ppn   = rd_ppn[lk_set];
        lk_perm  = rd_perm[lk_set];
    end

endmodule

// File: rtl/dtlb_check.sv
// Tag compare and permission check for one captured request.
// Purely combinational. It produces exactly one outcome for a valid request:
// bypass/grant, miss, or fault. A miss takes priority over a fault.
// Assumes: the entry inputs belong to the set selected by req_ea.
module dtlb_check
    import dtlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13
) (
    input  logic                        req_vld,
    input  logic                        req_we,
    input  logic                        req_sup,
    input  logic                        xl_en,
    input  logic [ADDR_W-1:0]           req_ea,
    input  logic                        lk_valid,
    input  logic [ADDR_W-PAGE_BITS-1:0] lk_vpn,
    input  logic [ADDR_W-PAGE_BITS-1:0] lk_ppn,
    input  dtlb_perm_t                  lk_perm,
    output logic                        ok,
    output logic                        miss,
    output logic                        fault,
    output logic [ADDR_W-1:0]           pa,
    output logic                        ci,
    output logic                        wr_stb
);
    logic tag_eq;
    logic allow;

    // Select the enable flag for this mode and access kind.
    always_comb begin
        tag_eq = lk_valid && (lk_vpn == req_ea[ADDR_W-1:PAGE_BITS]);
        unique case ({req_sup, req_we})
            2'b11:   allow = lk_perm.sup_wr;
            2'b10:   allow = lk_perm.sup_rd;
            2'b01:   allow = lk_perm.usr_wr;
            default: allow = lk_perm.usr_rd;
        endcase
    end

    // Resolve the single outcome and the physical address.
    always_comb begin
        ok     = 1'b0;
        miss   = 1'b0;
        fault  = 1'b0;
        pa     = '0;
        ci     = 1'b0;
        if (req_vld) begin
            if (!xl_en) begin
                ok = 1'b1;
                pa = req_ea;
            end else if (!tag_eq) begin
                miss = 1'b1;
            end else if (!allow) begin
                fault = 1'b1;
            end else begin
                ok = 1'b1;
                pa = {lk_ppn, req_ea[PAGE_BITS-1:0]};
                ci = lk_perm.no_cache;
            end
        end
        wr_stb = ok && req_we;
    end

endmodule

// File: rtl/dtlb_xlate.sv
// Top of the direct-mapped data translation buffer.
// Captures each request and the enable level, looks the request up
// combinationally in the next cycle, and latches the effective address of
// any miss or fault for the refill/repair software.
// Assumes: ADDR_W > PAGE_BITS + SET_BITS.
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 13,
    parameter int SET_BITS  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xl_en,
    input  logic                req_vld,
    input  logic                req_we,
    input  logic                req_sup,
    input  logic [ADDR_W-1:0]   req_ea,
    output logic                acc_ok,
    output logic                acc_miss,
    output logic                acc_fault,
    output logic [ADDR_W-1:0]   acc_pa,
    output logic                acc_ci,
    output logic                acc_wr_stb,
    output logic [ADDR_W-1:0]   fault_ea,
    input  logic                spr_we,
    input  logic                spr_sel,
    input  logic [SET_BITS-1:0] spr_set,
    input  logic [ADDR_W-1:0]   spr_wdata,
    output logic [ADDR_W-1:0]   spr_rdata
);
    localparam int PN_W = ADDR_W - PAGE_BITS;

    logic              r_vld, r_we, r_sup, r_en;
    logic [ADDR_W-1:0] r_ea;
    logic [SET_BITS-1:0] lk_set;
    logic              lk_valid;
    logic [PN_W-1:0]   lk_vpn, lk_ppn;
    dtlb_perm_t        lk_perm;

    // Capture the request and the enable level for next-cycle lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_vld <= 1'b0;
            r_we  <= 1'b0;
            r_sup <= 1'b0;
            r_en  <= 1'b0;
            r_ea  <= '0;
        end else begin
            r_vld <= req_vld;
            r_we  <= req_we;
            r_sup <= req_sup;
            r_en  <= xl_en;
            r_ea  <= req_ea;
        end
    end

    assign lk_set = r_ea[PAGE_BITS +: SET_BITS];

    dtlb_store #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS),
        .SET_BITS (SET_BITS)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .spr_we   (spr_we),
        .spr_sel  (spr_sel),
        .spr_set  (spr_set),
        .spr_wdata(spr_wdata),
        .spr_rdata(spr_rdata),
        .lk_set   (lk_set),
        .lk_valid (lk_valid),
        .lk_vpn   (lk_vpn),
        .lk_ppn   (lk_ppn),
        .lk_perm  (lk_perm)
    );

    dtlb_check #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS)
    ) i_check (
        .req_vld (r_vld),
        .req_we  (r_we),
        .req_sup (r_sup),
        .xl_en   (r_en),
        .req_ea  (r_ea),
        .lk_valid(lk_valid),
        .lk_vpn  (lk_vpn),
        .lk_ppn  (lk_ppn),
        .lk_perm (lk_perm),
        .ok      (acc_ok),
        .miss    (acc_miss),
        .fault   (acc_fault),
        .pa      (acc_pa),
        .ci      (acc_ci),
        .wr_stb  (acc_wr_stb)
    );

    // Latch the address of the failing access for the handler.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_ea <= '0;
        else if (acc_miss || acc_fault)
            fault_ea <= r_ea;
    end

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_ok, acc_miss, acc_fault})); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !r_vld |-> !(acc_ok || acc_miss || acc_fault)); // R9
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_miss || acc_fault) |-> (!acc_wr_stb && acc_pa == '0)); // R9
    AST_BYPASS_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_vld && !r_en) |-> (acc_ok && acc_pa == r_ea)); // R7
    AST_FEA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_miss || acc_fault) |=> fault_ea == $past(r_ea)); // R8
    AST_FEA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_miss || acc_fault) |=> $stable(fault_ea)); // R8

endmodule

// File: tb/test_dtlb_xlate.sv
// Self-checking bench with a behavioural per-clock reference model.
module test_dtlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_en = 1'b0;
    logic        req_vld = 1'b0, req_we = 1'b0, req_sup = 1'b0;
    logic [31:0] req_ea = '0;
    logic        acc_ok, acc_miss, acc_fault, acc_ci, acc_wr_stb;
    logic [31:0] acc_pa, fault_ea, spr_rdata;
    logic        spr_we = 1'b0, spr_sel = 1'b0;
    logic [4:0]  spr_set = '0;
    logic [31:0] spr_wdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    dtlb_xlate i_dtlb_xlate (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en),
        .req_vld(req_vld), .req_we(req_we), .req_sup(req_sup), .req_ea(req_ea),
        .acc_ok(acc_ok), .acc_miss(acc_miss), .acc_fault(acc_fault),
        .acc_pa(acc_pa), .acc_ci(acc_ci), .acc_wr_stb(acc_wr_stb),
        .fault_ea(fault_ea),
        .spr_we(spr_we), .spr_sel(spr_sel), .spr_set(spr_set),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_mr [32];
    logic [31:0] m_tr [32];
    logic        m_vld, m_we, m_sup, m_en;
    logic [31:0] m_ea, m_fea;
    logic        e_ok, e_miss, e_fault, e_ci, e_stb;
    logic [31:0] e_pa;

    task automatic model_eval();
        int set, fl;
        e_ok = 0; e_miss = 0; e_fault = 0; e_ci = 0; e_stb = 0; e_pa = 0;
        if (m_vld) begin
            if (!m_en) begin
                e_ok = 1; e_pa = m_ea;
            end else begin
                set = int'(m_ea[17:13]);
                fl  = m_sup ? (m_we ? 2 : 1) : (m_we ? 4 : 3);
                if (!m_mr[set][0] || m_mr[set][31:13] != m_ea[31:13]) e_miss = 1;
                else if (!m_tr[set][fl]) e_fault = 1;
                else begin
                    e_ok = 1;
                    e_pa = {m_tr[set][31:13], m_ea[12:0]};
                    e_ci = m_tr[set][0];
                end
            end
            e_stb = e_ok && m_we;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin m_mr[i] = 0; m_tr[i] = 0; end
            m_vld = 0; m_we = 0; m_sup = 0; m_en = 0; m_ea = 0; m_fea = 0;
        end else begin
            model_eval();
            if (e_miss || e_fault) m_fea = m_ea;
            if (spr_we) begin
                if (spr_sel) m_tr[spr_set] = spr_wdata & 32'hFFFFE01F;
                else         m_mr[spr_set] = spr_wdata & 32'hFFFFE001;
            end
            m_vld = req_vld; m_we = req_we; m_sup = req_sup;
            m_en = xl_en; m_ea = req_ea;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output against the model each clock.
    always @(negedge clk) begin
        if (!done) begin
            model_eval();
            chk("R1 acc_pa", acc_pa, e_pa);
            chk("R4 acc_miss", 32'(acc_miss), 32'(e_miss));
            chk("R5 acc_fault", 32'(acc_fault), 32'(e_fault));
            chk("R9 acc_ok", 32'(acc_ok), 32'(e_ok));
            chk("R9 acc_wr_stb", 32'(acc_wr_stb), 32'(e_stb));
            chk("R12 acc_ci", 32'(acc_ci), 32'(e_ci));
            chk("R8 fault_ea", fault_ea, m_fea);
            chk("R10 spr_rdata", spr_rdata, spr_sel ? m_tr[spr_set] : m_mr[spr_set]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic spr_write(input logic sel, input logic [4:0] set, input logic [31:0] d);
        @(posedge clk); #1;
        spr_we = 1; spr_sel = sel; spr_set = set; spr_wdata = d;
        @(posedge clk); #1;
        spr_we = 0;
    endtask

    task automatic spr_read(input logic sel, input logic [4:0] set, output logic [31:0] d);
        @(posedge clk); #1;
        spr_sel = sel; spr_set = set;
        @(negedge clk);
        d = spr_rdata;
    endtask

    // Request captured at the next edge; returns with outputs showing it.
    task automatic access(input logic [31:0] ea, input logic we, input logic sup);
        @(posedge clk); #1;
        req_vld = 1; req_we = we; req_sup = sup; req_ea = ea;
        @(posedge clk); #1;
        req_vld = 0;
        @(negedge clk);
    endtask

    localparam logic [31:0] EA_A = 32'h1234_6000;  // set 3
    localparam logic [31:0] EA_B = 32'h0000_E000;  // set 7

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R11 reset acc_ok", 32'(acc_ok), 0);
        chk("R11 reset acc_miss", 32'(acc_miss), 0);
        chk("R8 reset fault_ea", fault_ea, 0);
        spr_read(0, 5'd3, rd);  chk("R11 reset match word", rd, 0);
        spr_read(1, 5'd31, rd); chk("R11 reset translate word", rd, 0);

        // Bypass
        access(32'hDEAD_BEE4, 1, 0);
        chk("R7 bypass ok", 32'(acc_ok), 1);
        chk("R7 bypass pa", acc_pa, 32'hDEAD_BEE4);
        chk("R7 bypass miss", 32'(acc_miss | acc_fault), 0);
        chk("R9 bypass strobe", 32'(acc_wr_stb), 1);

        // Program set 3 and read back
        spr_write(0, 5'd3, 32'h1234_6FFF);
        spr_write(1, 5'd3, 32'h0008_0FFE);
        spr_read(0, 5'd3, rd); chk("R10 match readback", rd, 32'h1234_6001);
        spr_read(1, 5'd3, rd); chk("R10 translate readback", rd, 32'h0008_001E);

        @(posedge clk); #1 xl_en = 1;
        access(EA_A + 32'h10, 0, 1);
        chk("R1 hit pa", acc_pa, 32'h0008_0010);
        chk("R3 hit no miss", 32'(acc_miss), 0);
        access(EA_A + 32'h1FFC, 1, 1);
        chk("R3 same page hit", 32'(acc_ok), 1);
        chk("R1 top offset pa", acc_pa, 32'h0008_1FFC);
        chk("R9 store strobe", 32'(acc_wr_stb), 1);

        access(EA_A + 32'h2000, 1, 1);
        chk("R4 next page miss", 32'(acc_miss), 1);
        chk("R9 miss no strobe", 32'(acc_wr_stb), 0);
        @(negedge clk);
        chk("R8 miss address latched", fault_ea, EA_A + 32'h2000);

        // Walking one across every compared and index bit
        for (int k = 13; k < 32; k++) begin
            access(EA_A ^ (32'h1 << k), 0, 1);
            chk($sformatf("R3 bit %0d flipped miss", k), 32'(acc_miss), 1);
        end

        // Set selection
        spr_write(0, 5'd7, EA_B | 32'h1);
        spr_write(1, 5'd7, 32'h0040_001E);
        access(EA_B + 32'h8, 0, 0);
        chk("R2 set 7 pa", acc_pa, 32'h0040_0008);
        access(EA_A + 32'h8, 0, 0);
        chk("R2 set 3 untouched", acc_pa, 32'h0008_0008);

        // Permission flags one at a time
        for (int b = 1; b <= 4; b++) begin
            spr_write(1, 5'd3, 32'h0008_001E & ~(32'h1 << b));
            for (int c = 0; c < 4; c++) begin
                logic sup, we;
                int fl;
                sup = c[1]; we = c[0];
                fl = sup ? (we ? 2 : 1) : (we ? 4 : 3);
                access(EA_A + 32'h40, we, sup);
                chk($sformatf("R5 flag %0d mode %0d fault", b, c), 32'(acc_fault), 32'(fl == b));
                chk($sformatf("R5 flag %0d mode %0d ok", b, c), 32'(acc_ok), 32'(fl != b));
            end
        end
        @(negedge clk);
        chk("R8 fault address latched", fault_ea, EA_A + 32'h40);

        // Cache inhibit
        spr_write(1, 5'd3, 32'h0008_001F);
        access(EA_A, 0, 1);
        chk("R12 ci set", 32'(acc_ci), 1);
        spr_write(1, 5'd3, 32'h0008_001E);
        access(EA_A, 0, 1);
        chk("R12 ci clear", 32'(acc_ci), 0);

        // Invalidation
        spr_write(0, 5'd3, EA_A);
        access(EA_A, 0, 1);
        chk("R6 valid clear miss", 32'(acc_miss), 1);
        spr_read(0, 5'd3, rd); chk("R6 page number kept", rd, EA_A);
        spr_write(0, 5'd3, 32'h0);
        access(EA_A, 0, 1);
        chk("R6 zero word miss", 32'(acc_miss), 1);

        // Miss over fault
        spr_write(1, 5'd3, 32'h0008_0000);
        access(EA_A, 1, 0);
        chk("R4 miss priority miss", 32'(acc_miss), 1);
        chk("R4 miss priority no fault", 32'(acc_fault), 0);
        spr_write(0, 5'd3, EA_A | 32'h1);
        access(EA_A, 1, 0);
        chk("R5 no permission fault", 32'(acc_fault), 1);
        chk("R9 fault pa zero", acc_pa, 0);

        // Random phase
        for (int n = 0; n < 600; n++) begin
            logic [4:0]  rs;
            logic [13:0] hi;
            @(posedge clk); #1;
            rs = 5'($urandom % 4);
            hi = ($urandom % 2) ? 14'h0048 : 14'h0C00;
            req_vld = ($urandom % 3) != 0;
            req_we  = 1'($urandom);
            req_sup = 1'($urandom);
            req_ea  = {hi, rs, 13'($urandom)};
            xl_en   = ($urandom % 8) != 0;
            spr_we  = ($urandom % 4) == 0;
            spr_sel = 1'($urandom);
            spr_set = 5'($urandom % 4);
            hi = ($urandom % 2) ? 14'h0048 : 14'h0C00;
            spr_wdata = spr_sel ? $urandom : {hi, spr_set, 13'($urandom)};
        end
        @(posedge clk); #1;
        req_vld = 0; spr_we = 0;

        // Reset clears the table
        rst_n = 0;
        @(posedge clk); @(posedge clk); #1 rst_n = 1;
        spr_read(0, 5'd3, rd); chk("R11 table cleared", rd, 0);
        access(EA_A, 0, 1);
        chk("R11 after reset miss", 32'(acc_miss), 1);

        @(posedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL R9 watchdog actual=timeout expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule